// File: doc/BRIEF.md
# Clock output gating and power-down controller

This block decides, cycle by cycle, what each of six differential clock pairs and one single-ended reference clock output should be doing. Each output can be running, parked low on both legs, or floating. The block takes these inputs:

- an asynchronous power-good/power-down level;
- six active-low output-enable pins, also asynchronous;
- per-pair enable bits from a register file;
- a PLL lock flag;
- a reference-enable bit and a wake-on-LAN bit;
- a tri-level spread strap and a one-bit address strap.

The result is a 2-bit state code per output. The analog drivers use that code, as does the register file for readback.

The straps are captured once, when power-good is first seen high after reset. Afterwards, power-good acts only as a power-down control. Low enters power-down and high leaves it, and the captured straps are kept. The spread level sent to the PLL comes from the captured strap, unless software control of spread is enabled. In that case a register field chooses it.

The enable pins and power-good are synchronized to the output clock through two flops. Every state code is registered, so a pair changes its state only on a clock boundary. Enable changes therefore land within three output clock cycles.

Top module: `ckg_ctrl`

## Requirements
- R1: While synchronized power-good is low, every differential pair reports low/low (code 00).
- R2: The reference output reports high-Z (code 10) from reset until power-good is first seen high. After that it never reports high-Z again until the next reset.
- R3: With power-good high and PLL locked, pair i reports running (code 01) exactly when its register enable bit is 1 and its active-low pin is 0. Otherwise it reports low/low.
- R4: A register enable bit of 0 forces its pair to low/low whatever the level of its enable pin.
- R5: While the PLL lock flag is 0, no pair reports running.
- R6: The spread readback and the address select are captured on the first power-good high after reset. Later power-down and power-up cycles leave them unchanged, even if the strap pins have changed.
- R7: The spread strap input codes a tri-level pin as 00 (low), 01 (mid) and 11 (high); the input code 10 is taken as mid. The readback reports 00, 01 and 11 respectively.
- R8: When the software-spread bit is 1, the spread select output equals the 2-bit software field unchanged (00 off, 01 -0.25%, 11 -0.5%, 10 reserved). When the bit is 0, it equals the captured strap readback.
- R9: A change of power-good or an enable pin is reflected in the state codes after the third rising clock edge following the change. A change of a register bit, the lock flag, wake-on-LAN or reference enable is reflected after the first edge.
- R10: In power-down after the first power-up, the reference output runs if wake-on-LAN is 1 and reference enable is 1, and otherwise reports low. With power-good high, it runs exactly when reference enable is 1.
- R11: During reset, every pair reports 00 and the reference output reports 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_in | input | 1 | Power-good / power-down level, asynchronous |
| oe_n_in | input | 6 | Active-low pair enable pins, asynchronous |
| reg_oe | input | 6 | Register enable bit per pair |
| pll_lock | input | 1 | PLL lock flag |
| wol_en | input | 1 | Keep reference running in power-down |
| ref_oe | input | 1 | Reference output enable |
| ss_lvl | input | 2 | Tri-level spread strap (00 low, 01/10 mid, 11 high) |
| addr_pin | input | 1 | Address strap |
| ss_sw_en | input | 1 | Software control of spread |
| ss_sw_sel | input | 2 | Software spread field |
| dif_state | output | 12 | State code per pair, pair i at bits 2i+1:2i |
| ref_state | output | 2 | Reference output state code |
| ss_sel | output | 2 | Effective spread select |
| ss_rb | output | 2 | Captured strap readback |
| addr_sel | output | 1 | Captured address select |

## Verification
Power-good and pin changes reach the state codes three rising edges after they are applied. Register, lock and enable bits take one edge. The spread select follows the software field combinationally. The bench applies inputs one nanosecond after a rising edge. Its reference model keeps a short history of the asynchronous inputs and takes the entry from two edges back. All outputs are compared at each falling edge, so every value is sampled after the edge it depends on has settled. A directed test toggles one pin and checks that the pair still runs after the second edge and is low after the third.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [1:0] {
    ST_LOW = 2'b00,
    ST_RUN = 2'b01,
    ST_HIZ = 2'b10
  } ost_t;

  function automatic logic [1:0] strap_code(input logic [1:0] lvl);
    logic [1:0] c;
    case (lvl)
      2'b00:   c = 2'b00;
      2'b11:   c = 2'b11;
      default: c = 2'b01;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CW-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/ckg_strap.sv
module ckg_strap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_sync,
  input  logic [1:0] ss_lvl,
  input  logic       addr_pin,
  output logic       started,
  output logic [1:0] ss_rb,
  output logic       addr_sel
);
  import ckg_pkg::*;
  logic       started_q, capture;
  logic [1:0] rb_q;
  logic       addr_q;

  always_comb begin
    capture = pg_sync & ~started_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      rb_q      <= 2'b00;
      addr_q    <= 1'b0;
    end else if (capture) begin
      started_q <= 1'b1;
      rb_q      <= strap_code(ss_lvl);
      addr_q    <= addr_pin;
    end
  end

  assign started  = started_q;
  assign ss_rb    = rb_q;
  assign addr_sel = addr_q;

  // R6: once captured, the straps never move
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> ($stable(rb_q) && $stable(addr_q)));
endmodule

// File: rtl/ckg_dif_gate.sv
module ckg_dif_gate (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_sync,
  input  logic          lock,
  input  logic          reg_en,
  input  logic          pin_n_sync,
  output ckg_pkg::ost_t state
);
  import ckg_pkg::*;
  ost_t st_q, st_d;

  always_comb begin
    if (pg_sync && lock && reg_en && !pin_n_sync) st_d = ST_RUN;
    else                                          st_d = ST_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOW;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R4: a cleared register bit keeps the pair parked
  p_regoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> (st_q == ST_LOW));
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl #(
  parameter int NPAIR = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_in,
  input  logic [NPAIR-1:0]   oe_n_in,
  input  logic [NPAIR-1:0]   reg_oe,
  input  logic               pll_lock,
  input  logic               wol_en,
  input  logic               ref_oe,
  input  logic [1:0]         ss_lvl,
  input  logic               addr_pin,
  input  logic               ss_sw_en,
  input  logic [1:0]         ss_sw_sel,
  output logic [2*NPAIR-1:0] dif_state,
  output logic [1:0]         ref_state,
  output logic [1:0]         ss_sel,
  output logic [1:0]         ss_rb,
  output logic               addr_sel
);
  import ckg_pkg::*;
  localparam int SW = NPAIR + 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sh;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_s = rst_sh[1];

  logic [SW-1:0]    async_in, sync_out;
  logic             pg_sync;
  logic [NPAIR-1:0] oe_n_sync;
  assign async_in = {pg_in, oe_n_in};

  ckg_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_s), .d(async_in), .q(sync_out)
  );
  assign pg_sync   = sync_out[SW-1];
  assign oe_n_sync = sync_out[NPAIR-1:0];

  logic started;
  ckg_strap u_strap (
    .clk(clk), .rst_n(rst_s), .pg_sync(pg_sync), .ss_lvl(ss_lvl),
    .addr_pin(addr_pin), .started(started), .ss_rb(ss_rb), .addr_sel(addr_sel)
  );

  always_comb begin
    ss_sel = ss_sw_en ? ss_sw_sel : ss_rb;
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    ost_t st;
    ckg_dif_gate u_gate (
      .clk(clk), .rst_n(rst_s), .pg_sync(pg_sync), .lock(pll_lock),
      .reg_en(reg_oe[i]), .pin_n_sync(oe_n_sync[i]), .state(st)
    );
    assign dif_state[2*i+1:2*i] = st;
  end

  ost_t ref_q, ref_d;
  always_comb begin
    if (pg_sync)          ref_d = ref_oe ? ST_RUN : ST_LOW;
    else if (started)     ref_d = (wol_en && ref_oe) ? ST_RUN : ST_LOW;
    else                  ref_d = ST_HIZ;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ref_q <= ST_HIZ;
    else        ref_q <= ref_d;
  end
  assign ref_state = ref_q;

  // R1: power-down parks every pair
  p_pd_low_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !pg_sync |=> (dif_state == '0));
  // R5: nothing runs without lock
  p_nolock_r5: assert property (@(posedge clk) disable iff (!rst_s)
    !pll_lock |=> (dif_state == '0));
  // R2: after the first power-up the reference is always driven
  p_ref_drv_r2: assert property (@(posedge clk) disable iff (!rst_s)
    started |-> (ref_q != ST_HIZ));
  // R10: without wake-on-LAN the reference stops in power-down
  p_wol_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (!pg_sync && !wol_en) |=> (ref_q != ST_RUN));
endmodule

// File: tb/sim_ckg_ctrl.sv
`timescale 1ns/1ps
module sim_ckg_ctrl;
  localparam int N = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_in = 1'b0;
  logic [N-1:0] oe_n_in = '1;
  logic [N-1:0] reg_oe = '1;
  logic pll_lock = 1'b0, wol_en = 1'b0, ref_oe = 1'b1;
  logic [1:0] ss_lvl = 2'b00;
  logic addr_pin = 1'b0, ss_sw_en = 1'b0;
  logic [1:0] ss_sw_sel = 2'b00;
  logic [2*N-1:0] dif_state;
  logic [1:0] ref_state, ss_sel, ss_rb;
  logic addr_sel;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ckg_ctrl #(.NPAIR(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pg_in(pg_in), .oe_n_in(oe_n_in),
    .reg_oe(reg_oe), .pll_lock(pll_lock), .wol_en(wol_en), .ref_oe(ref_oe),
    .ss_lvl(ss_lvl), .addr_pin(addr_pin), .ss_sw_en(ss_sw_en),
    .ss_sw_sel(ss_sw_sel), .dif_state(dif_state), .ref_state(ref_state),
    .ss_sel(ss_sel), .ss_rb(ss_rb), .addr_sel(addr_sel)
  );

  // behavioural reference model
  bit pg_hist[$];
  logic [N-1:0] oe_hist[$];
  logic [2*N-1:0] m_dif;
  logic [1:0] m_ref, m_rb;
  bit m_started, m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_hist.delete(); oe_hist.delete();
      m_dif = '0; m_ref = 2'b10; m_rb = 2'b00; m_started = 0; m_addr = 0;
    end else begin
      bit pg2;
      logic [N-1:0] oe2;
      pg_hist.push_back(pg_in); oe_hist.push_back(oe_n_in);
      if (pg_hist.size() > 4) begin void'(pg_hist.pop_front()); void'(oe_hist.pop_front()); end
      pg2 = (pg_hist.size() >= 3) ? pg_hist[pg_hist.size()-3] : 1'b0;
      oe2 = (oe_hist.size() >= 3) ? oe_hist[oe_hist.size()-3] : '1;
      if (pg2)            m_ref = ref_oe ? 2'b01 : 2'b00;
      else if (m_started) m_ref = (wol_en && ref_oe) ? 2'b01 : 2'b00;
      else                m_ref = 2'b10;
      for (int i = 0; i < N; i++)
        m_dif[2*i +: 2] = (pg2 && pll_lock && reg_oe[i] && !oe2[i]) ? 2'b01 : 2'b00;
      if (pg2 && !m_started) begin
        m_started = 1;
        m_rb = (ss_lvl == 2'b00) ? 2'b00 : (ss_lvl == 2'b11) ? 2'b11 : 2'b01;
        m_addr = addr_pin;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic [1:0] e_ss;
    e_ss = ss_sw_en ? ss_sw_sel : m_rb;
    chk("R1 R3 R4 R5 dif_state", int'(dif_state), int'(m_dif));
    chk("R2 R10 ref_state", int'(ref_state), int'(m_ref));
    chk("R8 ss_sel", int'(ss_sel), int'(e_ss));
    chk("R6 R7 ss_rb", int'(ss_rb), int'(m_rb));
    chk("R6 addr_sel", int'(addr_sel), int'(m_addr));
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] lvl, input logic ad);
    rst_n = 1'b0; pg_in = 1'b0; ss_lvl = lvl; addr_pin = ad;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  initial begin
    step(2);
    // R11: reset codes
    @(negedge clk);
    chk("R11 reset dif", int'(dif_state), 0);
    chk("R11 reset ref", int'(ref_state), 2);
    do_reset(2'b01, 1'b1);
    reg_oe = '1; oe_n_in = '0; pll_lock = 1'b0;
    pg_in = 1'b1; step(6);           // R5: no lock
    pll_lock = 1'b1; step(4);        // R3: runs
    // R9: pin change lands after third edge
    oe_n_in[0] = 1'b1;
    @(negedge clk); chk("R9 pin edge0", int'(dif_state[1:0]), 1);
    @(negedge clk); chk("R9 pin edge1", int'(dif_state[1:0]), 1);
    @(negedge clk); chk("R9 pin edge2", int'(dif_state[1:0]), 1);
    @(negedge clk); chk("R9 pin edge3", int'(dif_state[1:0]), 0);
    step(1);
    oe_n_in = 6'b101010; step(4);
    reg_oe = 6'b110011; step(3);     // R4
    oe_n_in = '1; step(4);
    oe_n_in = '0; reg_oe = 6'b000000; step(3);
    reg_oe = 6'b111111; step(2);
    pll_lock = 1'b0; step(2); pll_lock = 1'b1; step(3);
    // power-down without wake-on-LAN, then strap change ignored (R6)
    wol_en = 1'b0; pg_in = 1'b0; ss_lvl = 2'b11; addr_pin = 1'b0; step(5);
    pg_in = 1'b1; step(5);
    // R10: wake-on-LAN
    wol_en = 1'b1; pg_in = 1'b0; step(5);
    ref_oe = 1'b0; step(3); ref_oe = 1'b1; step(3);
    pg_in = 1'b1; step(4); ref_oe = 1'b0; step(2); ref_oe = 1'b1; step(2);
    // R8: software spread
    ss_sw_en = 1'b1;
    for (int v = 0; v < 4; v++) begin ss_sw_sel = v[1:0]; step(2); end
    ss_sw_en = 1'b0; step(2);
    // R7: strap codings on fresh power-ups
    do_reset(2'b10, 1'b0); pg_in = 1'b1; step(5);
    do_reset(2'b11, 1'b1); pg_in = 1'b1; step(5);
    do_reset(2'b00, 1'b0); pg_in = 1'b1; step(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule